// File: doc/BRIEF.md
# Banked Per-CPU Private Register Decoder

This block decodes word accesses into a 4 KB private peripheral window that up to four CPUs share. Each access is sent to one of three target groups. The first is a small snoop-control register group. The second is a set of per-CPU interrupt-interface slots. The third is a set of per-CPU timer pairs. The interrupt-interface and timer targets each have two ways in. A "this CPU" alias window uses the requester ID that arrives with the access. Indexed windows pick the CPU from address bits, so any CPU can reach any other CPU's slot. The interrupt-interface and timer internals are not part of this block. Each slot is a small register stub, so the routing can be observed at the ports.

Slots that belong to CPUs at or above the configured count are hidden. Reads of them return zero, and writes to them are dropped. Read data comes back one cycle after the read strobe.

A three-state response machine sequences the result:
- **RS_IDLE**: no response is pending.
- **RS_DATA**: a normal read result is pending.
- **RS_FAULT**: an undefined snoop-control offset was read; the result is zero and `err` is raised.

The machine moves on every clock edge, as follows:
- **RS_IDLE → RS_DATA** on a plain read.
- **RS_IDLE → RS_FAULT** on a read of an undefined snoop-control offset.
- **RS_DATA or RS_FAULT → RS_IDLE** when no read is issued.
- **RS_DATA → RS_DATA** and **RS_FAULT → RS_FAULT** on back-to-back reads of the same kind.
- **RS_DATA ↔ RS_FAULT** on back-to-back reads of the other kind.

Top module: `priv_window_decoder`

## Requirements
- R1: Only address bits [11:0] are decoded. Bits [1:0] are also ignored, because every access is a full word. The upper address bits have no effect.
- R2: Snoop-control register 0x000 is the control register. Only its bit 0 is writable, and bits [31:1] read 0. It resets to 0.
- R3: Register 0x004 reads ((1<<N)-1)<<4 | (N-1), where N is the present CPU count. Register 0x008 reads 0. Register 0x00C reads 0. Writes to 0x004, 0x008 and 0x00C change nothing.
- R4: A read of any other offset below 0x100 returns 0 and raises `err` together with `rvalid` for one cycle. A write to such an offset is dropped.
- R5: Offsets 0x100–0x1FF reach the interrupt slot of CPU `req_cpu`. `sel_irq` is one-hot at that CPU while a strobe is high. `sub_off` carries {addr[7:2],2'b00}.
- R6: Offsets 0x200–0x5FF reach interrupt slot (offset-0x200)>>8. Each interrupt stub holds four words at sub-offsets 0x00, 0x04, 0x08 and 0x0C. Other sub-offsets read 0 and ignore writes.
- R7: Offsets 0x600–0x6FF reach the timer pair of `req_cpu`. Offsets 0x700–0xAFF reach timer pair (offset-0x700)>>8.
- R8: Inside a timer window, the timer index is cpu*2 + addr[5], and `sel_tmr` is one-hot at that index. The register word is addr[3:2]: 0 is load, 1 is counter, 2 is control and 3 is status. Address bits 4, 6 and 7 are ignored. `sub_off` carries {4'b0,addr[3:2],2'b00}.
- R9: An access whose target CPU (from the alias or from the address) is at or above N asserts no select line, reads 0 and is dropped on a write.
- R10: `ppi_irq[i]` equals bit 0 of timer i's status word. It is private interrupt 29+(i&1) of CPU i>>1.
- R11: A read returns `rdata` with `rvalid` in the cycle after `rd_en`. When `rd_en` and `wr_en` are high together, only the write happens and no `rvalid` follows.
- R12: Offsets 0xB00–0xFFF select nothing. Reads there return 0 without `err`, and writes are dropped.
- R13: After reset, `rvalid`, `err`, `rdata`, `ppi_irq` and every stub register are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Byte address of the access |
| wdata | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe (wins over `rd_en`) |
| req_cpu | input | CPU_W | ID of the requesting CPU |
| sel_scu | output | 1 | Snoop-control group selected |
| sel_irq | output | NCPU_MAX | One-hot interrupt-slot select |
| sel_tmr | output | 2*NCPU_MAX | One-hot timer select |
| sub_off | output | 8 | Offset inside the selected target |
| rdata | output | DW | Registered read data |
| rvalid | output | 1 | Read data valid |
| err | output | 1 | Undefined snoop-control read |
| ppi_irq | output | 2*NCPU_MAX | Timer private interrupt lines |

## Verification
The bench builds the block with NCPU_MAX=4 and NUM_CPU=3. With these values the configuration word is 0x72, and CPU 3 is absent. That puts the hidden-slot rules within reach both through the alias windows (req_cpu=3) and through the fourth indexed window. The bench sweeps every word offset of the 4 KB window with writes, varying the upper address bits. It then reads the whole window back with every requester ID. An arithmetic model checks each select vector, sub-offset, read word and error flag, including the aliasing of timer-window bits 4, 6 and 7.

// File: rtl/privdec_pkg.sv
package privdec_pkg;

    typedef enum logic [2:0] {
        RG_SCU,
        RG_IRQ_ALIAS,
        RG_IRQ_IDX,
        RG_TMR_ALIAS,
        RG_TMR_IDX,
        RG_VOID
    } region_e;

    typedef enum logic [2:0] {
        SR_CTRL,
        SR_CFG,
        SR_STAT,
        SR_INVAL,
        SR_UNDEF
    } scu_reg_e;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_DATA,
        RS_FAULT
    } rsp_state_e;

    localparam int OFF_W   = 12;
    localparam int WIN_SZ  = 256;
    localparam int SUB_W   = 8;

endpackage

// File: rtl/privdec_addr_class.sv
module privdec_addr_class
    import privdec_pkg::*;
#(
    parameter int NCPU_MAX = 4,
    parameter int NUM_CPU  = 4,
    localparam int CPU_W   = (NCPU_MAX > 1) ? $clog2(NCPU_MAX) : 1
) (
    input  logic [OFF_W-1:0] off,
    input  logic [CPU_W-1:0] req_cpu,
    output region_e          region,
    output logic [CPU_W-1:0] tgt_cpu,
    output logic             present,
    output scu_reg_e         scu_reg
);

    localparam int SCU_END       = WIN_SZ;
    localparam int IRQ_ALIAS_END = SCU_END + WIN_SZ;
    localparam int IRQ_IDX_BASE  = IRQ_ALIAS_END;
    localparam int IRQ_IDX_END   = IRQ_IDX_BASE + NCPU_MAX * WIN_SZ;
    localparam int TMR_ALIAS_END = IRQ_IDX_END + WIN_SZ;
    localparam int TMR_IDX_BASE  = TMR_ALIAS_END;
    localparam int TMR_IDX_END   = TMR_IDX_BASE + NCPU_MAX * WIN_SZ;

    logic [31:0] off_w;
    logic [31:0] cpu_w;

    assign off_w = {{(32-OFF_W){1'b0}}, off};

    always_comb begin
        region  = RG_VOID;
        tgt_cpu = req_cpu;
        if (off_w < 32'(SCU_END)) begin
            region = RG_SCU;
        end else if (off_w < 32'(IRQ_ALIAS_END)) begin
            region = RG_IRQ_ALIAS;
        end else if (off_w < 32'(IRQ_IDX_END)) begin
            region  = RG_IRQ_IDX;
            tgt_cpu = CPU_W'(off[11:8] - 4'(IRQ_IDX_BASE / WIN_SZ));
        end else if (off_w < 32'(TMR_ALIAS_END)) begin
            region = RG_TMR_ALIAS;
        end else if (off_w < 32'(TMR_IDX_END)) begin
            region  = RG_TMR_IDX;
            tgt_cpu = CPU_W'(off[11:8] - 4'(TMR_IDX_BASE / WIN_SZ));
        end
    end

    assign cpu_w   = {{(32-CPU_W){1'b0}}, tgt_cpu};
    assign present = (cpu_w < 32'(NUM_CPU));

    always_comb begin
        unique case ({off[7:2], 2'b00})
            8'h00:   scu_reg = SR_CTRL;
            8'h04:   scu_reg = SR_CFG;
            8'h08:   scu_reg = SR_STAT;
            8'h0C:   scu_reg = SR_INVAL;
            default: scu_reg = SR_UNDEF;
        endcase
    end

endmodule

// File: rtl/privdec_scu_regs.sv
module privdec_scu_regs
    import privdec_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  scu_reg_e      reg_sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_val,
    output logic          undef
);

    localparam int          CFG_INT = (((1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1);
    localparam logic [DW-1:0] CFG_VAL = DW'(CFG_INT);

    logic ctrl_q;
    logic unused_wdata;

    assign unused_wdata = ^wdata[DW-1:1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
        end else if (we && (reg_sel == SR_CTRL)) begin
            ctrl_q <= wdata[0];
        end
    end

    always_comb begin
        rd_val = '0;
        undef  = 1'b0;
        unique case (reg_sel)
            SR_CTRL:  rd_val = {{(DW-1){1'b0}}, ctrl_q};
            SR_CFG:   rd_val = CFG_VAL;
            SR_STAT:  rd_val = '0;
            SR_INVAL: rd_val = '0;
            SR_UNDEF: undef  = 1'b1;
            default:  undef  = 1'b1;
        endcase
    end

    // R2: control bit only moves on a write aimed at it
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && (reg_sel == SR_CTRL)) |=> $stable(ctrl_q));

endmodule

// File: rtl/privdec_reg_stub.sv
module privdec_reg_stub #(
    parameter int DW    = 32,
    parameter int NWORD = 4,
    localparam int IDX_W = (NWORD > 1) ? $clog2(NWORD) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IDX_W-1:0]           widx,
    input  logic [DW-1:0]              wdata,
    output logic [NWORD-1:0][DW-1:0]   words
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words <= '0;
        end else if (we) begin
            words[widx] <= wdata;
        end
    end

    // R9: stub contents only change under a routed write
    p_stub_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(words));

endmodule

// File: rtl/priv_window_decoder.sv
module priv_window_decoder
    import privdec_pkg::*;
#(
    parameter int NCPU_MAX = 4,
    parameter int NUM_CPU  = 4,
    parameter int DW       = 32,
    parameter int AW       = 32,
    localparam int CPU_W   = (NCPU_MAX > 1) ? $clog2(NCPU_MAX) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic [DW-1:0]         wdata,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic [CPU_W-1:0]      req_cpu,
    output logic                  sel_scu,
    output logic [NCPU_MAX-1:0]   sel_irq,
    output logic [2*NCPU_MAX-1:0] sel_tmr,
    output logic [SUB_W-1:0]      sub_off,
    output logic [DW-1:0]         rdata,
    output logic                  rvalid,
    output logic                  err,
    output logic [2*NCPU_MAX-1:0] ppi_irq
);

    localparam int NTMR       = 2 * NCPU_MAX;
    localparam int IRQ_WORDS  = 4;
    localparam int TMR_WORDS  = 4;
    localparam int TMR_STATUS = TMR_WORDS - 1;

    logic [OFF_W-1:0] off;
    logic             strobe;
    logic             rd_go;
    logic             wr_go;
    logic             unused_hi;

    assign off       = addr[OFF_W-1:0];
    assign strobe    = rd_en | wr_en;
    assign wr_go     = wr_en;
    assign rd_go     = rd_en & ~wr_en;
    assign unused_hi = ^addr[AW-1:OFF_W];

    // ---------------- address classification ----------------
    region_e          region;
    logic [CPU_W-1:0] tgt_cpu;
    logic             present;
    scu_reg_e         scu_reg;

    privdec_addr_class #(
        .NCPU_MAX (NCPU_MAX),
        .NUM_CPU  (NUM_CPU)
    ) u_class (
        .off     (off),
        .req_cpu (req_cpu),
        .region  (region),
        .tgt_cpu (tgt_cpu),
        .present (present),
        .scu_reg (scu_reg)
    );

    logic           in_irq;
    logic           in_tmr;
    logic           irq_word_ok;
    logic [CPU_W:0] tmr_idx;

    assign in_irq      = (region == RG_IRQ_ALIAS) || (region == RG_IRQ_IDX);
    assign in_tmr      = (region == RG_TMR_ALIAS) || (region == RG_TMR_IDX);
    assign irq_word_ok = (off[7:4] == 4'd0);
    assign tmr_idx     = {tgt_cpu, off[5]};

    // ---------------- select lines ----------------
    always_comb begin
        sel_scu = strobe && (region == RG_SCU);
        sel_irq = '0;
        sel_tmr = '0;
        if (strobe && present && in_irq) begin
            sel_irq[tgt_cpu] = 1'b1;
        end
        if (strobe && present && in_tmr) begin
            sel_tmr[tmr_idx] = 1'b1;
        end
    end

    always_comb begin
        unique case (region)
            RG_SCU, RG_IRQ_ALIAS, RG_IRQ_IDX: sub_off = {off[7:2], 2'b00};
            RG_TMR_ALIAS, RG_TMR_IDX:         sub_off = {4'b0000, off[3:2], 2'b00};
            default:                          sub_off = '0;
        endcase
    end

    // ---------------- snoop-control group ----------------
    logic [DW-1:0] scu_rd;
    logic          scu_undef;

    privdec_scu_regs #(
        .NUM_CPU (NUM_CPU),
        .DW      (DW)
    ) u_scu (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_go && sel_scu),
        .reg_sel (scu_reg),
        .wdata   (wdata),
        .rd_val  (scu_rd),
        .undef   (scu_undef)
    );

    // ---------------- interrupt-interface stubs ----------------
    logic [NCPU_MAX-1:0][IRQ_WORDS-1:0][DW-1:0] irq_words;

    for (genvar g = 0; g < NCPU_MAX; g++) begin : g_irq
        if (g < NUM_CPU) begin : g_on
            privdec_reg_stub #(
                .DW    (DW),
                .NWORD (IRQ_WORDS)
            ) u_stub (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_go && sel_irq[g] && irq_word_ok),
                .widx  (off[3:2]),
                .wdata (wdata),
                .words (irq_words[g])
            );
        end else begin : g_off
            assign irq_words[g] = '0;
        end
    end

    // ---------------- timer stubs ----------------
    logic [NTMR-1:0][TMR_WORDS-1:0][DW-1:0] tmr_words;

    for (genvar t = 0; t < NTMR; t++) begin : g_tmr
        if ((t / 2) < NUM_CPU) begin : g_on
            privdec_reg_stub #(
                .DW    (DW),
                .NWORD (TMR_WORDS)
            ) u_stub (
                .clk   (clk),
                .rst_n (rst_n),
                .we    (wr_go && sel_tmr[t]),
                .widx  (off[3:2]),
                .wdata (wdata),
                .words (tmr_words[t])
            );
        end else begin : g_off
            assign tmr_words[t] = '0;
        end
        assign ppi_irq[t] = tmr_words[t][TMR_STATUS][0];
    end

    // ---------------- read data mux ----------------
    logic [DW-1:0] rd_val;
    logic          rd_fault;

    always_comb begin
        rd_val   = '0;
        rd_fault = 1'b0;
        unique case (region)
            RG_SCU: begin
                rd_val   = scu_rd;
                rd_fault = scu_undef;
            end
            RG_IRQ_ALIAS, RG_IRQ_IDX: begin
                if (present && irq_word_ok) begin
                    rd_val = irq_words[tgt_cpu][off[3:2]];
                end
            end
            RG_TMR_ALIAS, RG_TMR_IDX: begin
                if (present) begin
                    rd_val = tmr_words[tmr_idx][off[3:2]];
                end
            end
            default: rd_val = '0;
        endcase
    end

    // ---------------- response state machine ----------------
    rsp_state_e state_q;
    rsp_state_e state_d;
    logic [DW-1:0] rdata_q;

    always_comb begin
        state_d = RS_IDLE;
        if (rd_go) begin
            state_d = rd_fault ? RS_FAULT : RS_DATA;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_go && !rd_fault) begin
            rdata_q <= rd_val;
        end else begin
            rdata_q <= '0;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE:  begin rvalid = 1'b0; err = 1'b0; end
            RS_DATA:  begin rvalid = 1'b1; err = 1'b0; end
            RS_FAULT: begin rvalid = 1'b1; err = 1'b1; end
            default:  begin rvalid = 1'b0; err = 1'b0; end
        endcase
    end

    assign rdata = rdata_q;

    // ---------------- assertions ----------------
    // R5 and R8: never more than one target selected
    p_sel_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_scu, sel_irq, sel_tmr}));

    // R11: a read answers in the next cycle
    p_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> rvalid);

    // R11: a write, even with rd_en high, gives no response
    p_write_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !rvalid);

    // R4: a fault returns zero data
    p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (rvalid && (rdata == '0)));

    // R9: absent CPU targets are never selected
    p_hidden_nosel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !present && (in_irq || in_tmr)) |-> ((sel_irq == '0) && (sel_tmr == '0)));

endmodule

// File: tb/priv_window_decoder_tb.sv
`timescale 1ns/100ps
module priv_window_decoder_tb;

    localparam int NMAX = 4;
    localparam int N    = 3;
    localparam int DW   = 32;
    localparam int AW   = 32;
    localparam logic [31:0] CFG = 32'((((1 << N) - 1) << 4) | (N - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic rd_en = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] req_cpu = '0;
    logic sel_scu;
    logic [NMAX-1:0] sel_irq;
    logic [2*NMAX-1:0] sel_tmr;
    logic [7:0] sub_off;
    logic [DW-1:0] rdata;
    logic rvalid;
    logic err;
    logic [2*NMAX-1:0] ppi_irq;

    always #2 clk = ~clk;

    priv_window_decoder #(
        .NCPU_MAX (NMAX),
        .NUM_CPU  (N),
        .DW       (DW),
        .AW       (AW)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wdata   (wdata),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .req_cpu (req_cpu),
        .sel_scu (sel_scu),
        .sel_irq (sel_irq),
        .sel_tmr (sel_tmr),
        .sub_off (sub_off),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .err     (err),
        .ppi_irq (ppi_irq)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] gic_m [NMAX][4];
    logic [31:0] tmr_m [2*NMAX][4];
    logic        ctrl_m;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kind: 0 void, 1 snoop-control, 2 interrupt slot, 3 timer, 4 absent CPU
    function automatic void decode(input int off, input int cpu, output int kind,
                                   output int slot, output bit wok);
        int c;
        kind = 0; slot = 0; wok = 1'b1; c = 0;
        if (off < 'h100) begin
            kind = 1;
        end else if (off < 'h200) begin
            kind = 2; c = cpu;
        end else if (off < 'h600) begin
            kind = 2; c = (off - 'h200) >> 8;
        end else if (off < 'h700) begin
            kind = 3; c = cpu;
        end else if (off < 'hB00) begin
            kind = 3; c = (off - 'h700) >> 8;
        end
        if (kind == 2) begin
            slot = c;
            wok  = (((off >> 4) & 'hF) == 0);
        end
        if (kind == 3) slot = c * 2 + ((off >> 5) & 1);
        if ((kind == 2 || kind == 3) && c >= N) kind = 4;
    endfunction

    function automatic logic [31:0] exp_rd(input int off, input int cpu, output bit e);
        int kind, slot; bit wok;
        decode(off, cpu, kind, slot, wok);
        e = 1'b0;
        exp_rd = '0;
        if (kind == 1) begin
            case (off & 'hFC)
                'h00: exp_rd = {31'd0, ctrl_m};
                'h04: exp_rd = CFG;
                'h08: exp_rd = '0;
                'h0C: exp_rd = '0;
                default: e = 1'b1;
            endcase
        end else if (kind == 2) begin
            if (wok) exp_rd = gic_m[slot][(off >> 2) & 3];
        end else if (kind == 3) begin
            exp_rd = tmr_m[slot][(off >> 2) & 3];
        end
    endfunction

    task automatic model_wr(input int off, input int cpu, input logic [31:0] d);
        int kind, slot; bit wok;
        decode(off, cpu, kind, slot, wok);
        if (kind == 1 && (off & 'hFC) == 0) ctrl_m = d[0];
        if (kind == 2 && wok) gic_m[slot][(off >> 2) & 3] = d;
        if (kind == 3) tmr_m[slot][(off >> 2) & 3] = d;
    endtask

    function automatic string tag(input int kind);
        case (kind)
            1: tag = "R1 R2 R3 scu";
            2: tag = "R1 R6 irq";
            3: tag = "R7 R8 timer";
            4: tag = "R9 absent";
            default: tag = "R12 void";
        endcase
    endfunction

    task automatic access(input int off, input int cpu, input bit wr, input bit rd,
                          input logic [31:0] d, input logic [19:0] hi);
        int kind, slot; bit wok; bit e;
        logic [12:0] exp_sel;
        logic [7:0] exp_sub;
        logic [31:0] er;
        decode(off, cpu, kind, slot, wok);
        er = exp_rd(off, cpu, e);
        exp_sel = '0;
        if (kind == 1) exp_sel[12] = 1'b1;
        if (kind == 2) exp_sel[8 + slot] = 1'b1;
        if (kind == 3) exp_sel[slot] = 1'b1;
        if (off < 'h600) exp_sub = 8'(off & 'hFC);
        else if (off < 'hB00) exp_sub = 8'(off & 'hC);
        else exp_sub = '0;
        @(negedge clk);
        addr = {hi, off[11:0]};
        req_cpu = cpu[1:0];
        wdata = d;
        wr_en = wr;
        rd_en = rd;
        #0.5;
        chk({sel_scu, sel_irq, sel_tmr} == exp_sel, {tag(kind), " R5 select"},
            32'({sel_scu, sel_irq, sel_tmr}), 32'(exp_sel));
        chk(sub_off == exp_sub, "R5 R8 sub_off", 32'(sub_off), 32'(exp_sub));
        @(negedge clk);
        wr_en = 1'b0;
        rd_en = 1'b0;
        if (rd && !wr) begin
            chk(rvalid == 1'b1, "R11 rvalid", 32'(rvalid), 32'd1);
            chk(rdata == er, {tag(kind), " read"}, rdata, er);
            chk(err == e, "R4 err", 32'(err), 32'(e));
        end else begin
            chk(rvalid == 1'b0, "R11 no response", 32'(rvalid), 32'd0);
        end
        if (wr) model_wr(off, cpu, d);
    endtask

    initial begin
        for (int c = 0; c < NMAX; c++)
            for (int w = 0; w < 4; w++) gic_m[c][w] = '0;
        for (int t = 0; t < 2 * NMAX; t++)
            for (int w = 0; w < 4; w++) tmr_m[t][w] = '0;
        ctrl_m = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(rvalid == 1'b0, "R13 rvalid", 32'(rvalid), 0);
        chk(err == 1'b0, "R13 err", 32'(err), 0);
        chk(rdata == '0, "R13 rdata", rdata, 0);
        chk(ppi_irq == '0, "R13 ppi", 32'(ppi_irq), 0);
        access('h000, 0, 0, 1, '0, 20'h0);
        access('h200, 0, 0, 1, '0, 20'h0);
        access('h720, 0, 0, 1, '0, 20'h0);

        // write sweep over the whole window
        for (int off = 0; off < 4096; off += 4) begin
            int cpu = (off >> 2) % 4;
            logic [31:0] d = 32'h5A00_0000 | 32'(off << 8) | 32'(cpu << 4) | 32'((off >> 2) & 1);
            access(off, cpu, 1, 0, d, 20'(off * 37 + cpu));
        end

        // R10 interrupt lines after the sweep
        @(negedge clk);
        for (int t = 0; t < 2 * NMAX; t++) begin
            logic ev = (t / 2 < N) ? tmr_m[t][3][0] : 1'b0;
            chk(ppi_irq[t] == ev, "R10 ppi", 32'(ppi_irq[t]), 32'(ev));
        end

        // clear status of timer 3 via alias window, then recheck
        access('h62C, 1, 1, 0, 32'h0, 20'h12345);
        access('h7EC, 0, 1, 0, 32'h0, 20'h00001);
        @(negedge clk);
        for (int t = 0; t < 2 * NMAX; t++) begin
            logic ev = (t / 2 < N) ? tmr_m[t][3][0] : 1'b0;
            chk(ppi_irq[t] == ev, "R10 ppi cleared", 32'(ppi_irq[t]), 32'(ev));
        end

        // R2 control bit set with all ones, R11 simultaneous strobes
        access('h000, 2, 1, 1, 32'hFFFF_FFFF, 20'hFFFFF);
        access('h000, 0, 0, 1, '0, 20'h0);
        access('h004, 0, 1, 0, 32'hFFFF_FFFF, 20'h0);
        access('h00C, 0, 1, 0, 32'hFFFF_FFFF, 20'h0);

        // read sweep with every requester
        for (int cpu = 0; cpu < 4; cpu++) begin
            for (int off = 0; off < 4096; off += 4) begin
                access(off, cpu, 0, 1, '0, 20'(off * 11 + cpu * 5));
            end
        end

        // back-to-back read to fault then data
        access('h010, 0, 0, 1, '0, 20'h0);
        access('h004, 0, 0, 1, '0, 20'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule